// File: doc/BRIEF.md
# Supply Glitch Detector Control Sequencer

This block sits between a software-written control word and an analog supply-glitch detector. It stores the detector's configuration: a low-voltage threshold select, a high-voltage threshold select and a low-pass filter bandwidth select. It also drives the detector's active-low power-down and active-low reset pins. Software does not drive those pins directly. The sequencer enforces a minimum reset hold after the detector is powered up. It also inserts an automatic reset pulse whenever a threshold or filter setting changes, so the comparator never raises a false glitch event.

The timing minimums are given in nanoseconds and converted into clock cycles from the clock period parameter. Each is rounded up, with a floor of one cycle. The default is a 10 ns clock, which gives a 10-cycle power-up hold and a 20-cycle settings pulse. A read-only busy output reports whether a timed hold or pulse is running. The configuration pins are copied from the stored settings only while the detector reset pin is low.

Top module: `glitch_guard_ctrl`

## Requirements
- R1: The chip reset input (active low, asynchronous) clears all state. det_pwr_n=0, det_rst_n=0, busy=0, rd_data=0 and all three select outputs are 0.
- R2: The control word places power-enable at bit 31, reset-release request at bit 30, filter select at bits 18:16, high threshold at bits 13:8 and low threshold at bits 5:0. A write takes effect at the clock edge where wr_en is high. rd_data returns the stored fields in those positions, and every other bit reads 0 whatever was written.
- R3: det_pwr_n equals the stored bit 31 from the cycle after the write. A write that raises bit 31 from 0 holds det_rst_n low for HOLD = max(1, ceil(100 ns / period)) cycles after the write edge, and det_rst_n never rises while det_pwr_n is 0.
- R4: A write that changes any of the three selects while powered (or while powering up) holds det_rst_n low for PULSE = max(1, ceil(200 ns / period)) cycles after the write edge, starting the cycle after that edge. The same change made while powered down starts no timer.
- R5: A settings change written while a hold or pulse is running restarts the full PULSE count from that write edge.
- R6: Writing bit 31 low forces det_rst_n low and busy low in the next cycle, cancelling any running timer.
- R7: busy is 1 exactly during the cycles of a running hold or pulse, and det_rst_n is 0 whenever busy is 1.
- R8: The select outputs take the stored settings one cycle after a cycle in which det_rst_n is 0. They never change in a cycle following one with det_rst_n at 1.
- R9: Rewriting identical select values while powered starts no pulse, and det_rst_n stays high.
- R10: Once no timer runs and power is on, det_rst_n follows the stored bit 30. A request left at 0 keeps the detector in reset. A release written while idle takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word written when wr_en is high |
| rd_data | output | 32 | Stored control word, reserved bits zero |
| busy | output | 1 | A timed reset hold or pulse is running |
| det_pwr_n | output | 1 | Detector power-down, active low |
| det_rst_n | output | 1 | Detector reset, active low |
| det_lo_sel | output | 6 | Low threshold select to the detector |
| det_hi_sel | output | 6 | High threshold select to the detector |
| det_flt_sel | output | 3 | Filter bandwidth select to the detector |

## Verification
The bench checks the release edge one cycle on either side of the expected count, for both the power-up hold and the settings pulse. An off-by-one counter would release the detector early and let a false trigger through. A second settings write in the middle of a pulse must push the release out a full pulse from the later write; a design that ignored it would release on the first write's schedule. Other cases exercised are a power-down during a pulse, which must cancel it, and an identical rewrite, which must not pulse. The select pins are sampled in the cycle of a change, and a design that forwarded settings while active would show the new values there.

// File: rtl/gg_pkg.sv
package gg_pkg;

    localparam int WORD_W  = 32;
    localparam int LO_W    = 6;
    localparam int HI_W    = 6;
    localparam int FLT_W   = 3;

    // field positions decoded by software
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = 8;
    localparam int FLT_LSB = 16;
    localparam int RST_BIT = 30;
    localparam int PWR_BIT = 31;

    typedef struct packed {
        logic [FLT_W-1:0] flt;
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
    } gg_cfg_t;

    localparam int CFG_W = $bits(gg_cfg_t);

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_PULSE = 2'd2,
        ST_READY = 2'd3
    } gg_state_e;

    // round a time up to whole cycles, never below one
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/gg_ctrl_reg.sv
module gg_ctrl_reg
    import gg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              pwr_q_o,
    output logic              rel_req_o,
    output gg_cfg_t           cfg_o,
    output logic [WORD_W-1:0] rd_data,
    output logic              pwr_up_o,
    output logic              pwr_dn_o,
    output logic              cfg_chg_o
);

    typedef struct packed {
        logic    pwr;
        logic    rel;
        gg_cfg_t cfg;
    } ctrl_t;

    ctrl_t   ctrl_d, ctrl_q;
    gg_cfg_t wr_cfg;
    logic    wr_pwr;
    logic    unused_rsvd;

    always_comb begin
        wr_cfg.lo  = wr_data[LO_LSB  +: LO_W];
        wr_cfg.hi  = wr_data[HI_LSB  +: HI_W];
        wr_cfg.flt = wr_data[FLT_LSB +: FLT_W];
        wr_pwr     = wr_data[PWR_BIT];

        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.pwr = wr_pwr;
            ctrl_d.rel = wr_data[RST_BIT];
            ctrl_d.cfg = wr_cfg;
        end

        pwr_up_o  = wr_en &  wr_pwr & ~ctrl_q.pwr;
        pwr_dn_o  = wr_en & ~wr_pwr;
        cfg_chg_o = wr_en & (wr_cfg != ctrl_q.cfg);

        rd_data = '0;
        rd_data[PWR_BIT]             = ctrl_q.pwr;
        rd_data[RST_BIT]             = ctrl_q.rel;
        rd_data[FLT_LSB +: FLT_W]    = ctrl_q.cfg.flt;
        rd_data[HI_LSB  +: HI_W]     = ctrl_q.cfg.hi;
        rd_data[LO_LSB  +: LO_W]     = ctrl_q.cfg.lo;
    end

    // reserved write bits are dropped
    assign unused_rsvd = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign pwr_q_o   = ctrl_q.pwr;
    assign rel_req_o = ctrl_q.rel;
    assign cfg_o     = ctrl_q.cfg;

    // R3: power bit follows the written value one cycle later
    p_pwr_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pwr_q_o == $past(wr_data[PWR_BIT])));

    // R2: stored word is unchanged without a write
    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/gg_seq.sv
module gg_seq
    import gg_pkg::*;
#(
    parameter int HOLD_CYC  = 10,
    parameter int PULSE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_q,
    input  logic rel_req,
    input  logic pwr_up,
    input  logic pwr_dn,
    input  logic cfg_chg,
    output logic det_rst_n,
    output logic busy
);

    localparam int CHG_CYC = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
    localparam int CW      = $clog2(CHG_CYC + 1);

    typedef struct packed {
        gg_state_e        st;
        logic [CW-1:0]    cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic load;

    always_comb begin
        seq_d = seq_q;
        load  = 1'b0;
        if (pwr_dn) begin
            seq_d.st  = ST_OFF;
            seq_d.cnt = '0;
        end else if (cfg_chg && (pwr_q || pwr_up)) begin
            seq_d.st  = ST_PULSE;
            seq_d.cnt = CW'(CHG_CYC - 1);
            load      = 1'b1;
        end else if (pwr_up) begin
            seq_d.st  = ST_HOLD;
            seq_d.cnt = CW'(HOLD_CYC - 1);
            load      = 1'b1;
        end else begin
            case (seq_q.st)
                ST_HOLD, ST_PULSE: begin
                    if (seq_q.cnt == '0) begin
                        seq_d.st = ST_READY;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_OFF, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign busy      = (seq_q.st == ST_HOLD) || (seq_q.st == ST_PULSE);
    assign det_rst_n = (seq_q.st == ST_READY) && rel_req;

    // R6: an unpowered detector is always held in reset
    p_unpowered_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_q |-> !det_rst_n);

    // R7: a running timer keeps reset asserted
    p_busy_holds_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !det_rst_n);

    // R7: the timer counts down by one without new events
    p_countdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !pwr_dn && (seq_q.cnt != '0)) |=>
            (busy && (seq_q.cnt == $past(seq_q.cnt) - 1'b1)));

    // R4: a load never exceeds the longest window
    p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (seq_q.cnt < CW'(CHG_CYC)));

endmodule

// File: rtl/gg_pin_stage.sv
module gg_pin_stage
    import gg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    det_rst_n,
    input  gg_cfg_t cfg,
    output gg_cfg_t pins
);

    gg_cfg_t pins_d, pins_q;

    always_comb begin
        pins_d = pins_q;
        if (!det_rst_n) pins_d = cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    assign pins = pins_q;

    // R8: settings frozen while the detector was active
    p_pins_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(det_rst_n) |-> $stable(pins_q));

endmodule

// File: rtl/glitch_guard_ctrl.sv
module glitch_guard_ctrl
    import gg_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int HOLD_NS       = 100,
    parameter int PULSE_NS      = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              det_pwr_n,
    output logic              det_rst_n,
    output logic [LO_W-1:0]   det_lo_sel,
    output logic [HI_W-1:0]   det_hi_sel,
    output logic [FLT_W-1:0]  det_flt_sel
);

    localparam int HOLD_CYC  = ns_to_cycles(HOLD_NS,  CLK_PERIOD_NS);
    localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_PERIOD_NS);

    logic    pwr_q, rel_req, pwr_up, pwr_dn, cfg_chg;
    gg_cfg_t cfg, pins;

    gg_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pwr_q_o   (pwr_q),
        .rel_req_o (rel_req),
        .cfg_o     (cfg),
        .rd_data   (rd_data),
        .pwr_up_o  (pwr_up),
        .pwr_dn_o  (pwr_dn),
        .cfg_chg_o (cfg_chg)
    );

    gg_seq #(
        .HOLD_CYC  (HOLD_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_q     (pwr_q),
        .rel_req   (rel_req),
        .pwr_up    (pwr_up),
        .pwr_dn    (pwr_dn),
        .cfg_chg   (cfg_chg),
        .det_rst_n (det_rst_n),
        .busy      (busy)
    );

    gg_pin_stage u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_rst_n (det_rst_n),
        .cfg       (cfg),
        .pins      (pins)
    );

    assign det_pwr_n   = pwr_q;
    assign det_lo_sel  = pins.lo;
    assign det_hi_sel  = pins.hi;
    assign det_flt_sel = pins.flt;

    // R3: reset is only released on a powered detector
    p_release_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_rst_n) |-> det_pwr_n);

endmodule

// File: tb/glitch_guard_ctrl_bench.sv
module glitch_guard_ctrl_bench;

    localparam int CLK_NS  = 10;
    localparam int HOLD_N  = ((100 + CLK_NS - 1) / CLK_NS < 1) ? 1 : (100 + CLK_NS - 1) / CLK_NS;
    localparam int PULSE_N = ((200 + CLK_NS - 1) / CLK_NS < 1) ? 1 : (200 + CLK_NS - 1) / CLK_NS;

    localparam int K_RST = 0, K_PWR = 1, K_BUSY = 2, K_RD = 3, K_PINS = 4;

    typedef struct {
        int          cyc;
        int          kind;
        logic [31:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, det_pwr_n, det_rst_n;
    logic [5:0]  det_lo_sel, det_hi_sel;
    logic [2:0]  det_flt_sel;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    glitch_guard_ctrl #(.CLK_PERIOD_NS(CLK_NS)) u_glitch_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .det_pwr_n(det_pwr_n),
        .det_rst_n(det_rst_n), .det_lo_sel(det_lo_sel),
        .det_hi_sel(det_hi_sel), .det_flt_sel(det_flt_sel)
    );

    always #(CLK_NS / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pk(input int f, input int h, input int l);
        return {17'd0, 3'(f), 6'(h), 6'(l)};
    endfunction

    function automatic logic [31:0] word(input bit p, input bit r,
                                         input int f, input int h, input int l);
        logic [31:0] w;
        w = '0;
        w[31] = p; w[30] = r;
        w[18:16] = 3'(f); w[13:8] = 6'(h); w[5:0] = 6'(l);
        return w;
    endfunction

    // driver side: queue an expectation in cycle order
    task automatic expect_at(input int c, input int kind, input logic [31:0] v, input string req);
        exp_t e;
        int   i;
        e.cyc = c; e.kind = kind; e.val = v; e.req = req;
        i = 0;
        while (i < exp_q.size() && exp_q[i].cyc <= c) i++;
        exp_q.insert(i, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_raw(input logic [31:0] d, output int c0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        c0 = cyc;
    endtask

    task automatic wr(input bit p, input bit r, input int f, input int h, input int l,
                      output int c0);
        wr_raw(word(p, r, f, h, l), c0);
    endtask

    function automatic logic [31:0] actual(input int kind);
        case (kind)
            K_RST:   return {31'd0, det_rst_n};
            K_PWR:   return {31'd0, det_pwr_n};
            K_BUSY:  return {31'd0, busy};
            K_RD:    return rd_data;
            default: return {17'd0, det_flt_sel, det_hi_sel, det_lo_sel};
        endcase
    endfunction

    // monitor: pop and compare as results appear
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
                exp_t e;
                logic [31:0] a;
                e = exp_q.pop_front();
                a = actual(e.kind);
                checks++;
                if (a !== e.val) begin
                    failures++;
                    $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                             e.req, e.kind, cyc, a, e.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c0, c1;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        expect_at(cyc, K_RST,  0, "R1");
        expect_at(cyc, K_PWR,  0, "R1");
        expect_at(cyc, K_BUSY, 0, "R1");
        expect_at(cyc, K_RD,   0, "R1");
        expect_at(cyc, K_PINS, 0, "R1");

        // R4/R8: settings while powered down, no timer, pins follow
        wr(0, 1, 3, 9, 5, c0);
        expect_at(c0,     K_RD,   32'h4003_0905, "R2");
        expect_at(c0,     K_BUSY, 0, "R4");
        expect_at(c0 + 1, K_PINS, pk(3, 9, 5), "R8");
        expect_at(c0 + 1, K_RST,  0, "R4");
        idle(3);

        // R3/R7: power-up hold
        wr(1, 1, 3, 9, 5, c0);
        expect_at(c0,              K_PWR,  1, "R3");
        expect_at(c0,              K_BUSY, 1, "R7");
        expect_at(c0 + HOLD_N - 1, K_RST,  0, "R3");
        expect_at(c0 + HOLD_N - 1, K_BUSY, 1, "R7");
        expect_at(c0 + HOLD_N,     K_RST,  1, "R3");
        expect_at(c0 + HOLD_N,     K_BUSY, 0, "R7");
        idle(HOLD_N + 2);

        // R4/R8: settings change while active
        wr(1, 1, 3, 9, 7, c0);
        expect_at(c0,               K_RST,  0, "R4");
        expect_at(c0,               K_PINS, pk(3, 9, 5), "R8");
        expect_at(c0 + 1,           K_PINS, pk(3, 9, 7), "R8");
        expect_at(c0 + PULSE_N - 1, K_RST,  0, "R4");
        expect_at(c0 + PULSE_N - 1, K_BUSY, 1, "R7");
        expect_at(c0 + PULSE_N,     K_RST,  1, "R4");
        expect_at(c0 + PULSE_N,     K_BUSY, 0, "R7");
        idle(PULSE_N + 2);

        // R9: identical rewrite
        wr(1, 1, 3, 9, 7, c0);
        expect_at(c0,     K_RST,  1, "R9");
        expect_at(c0,     K_BUSY, 0, "R9");
        expect_at(c0 + 2, K_RST,  1, "R9");
        idle(3);

        // R5: restart during pulse
        wr(1, 1, 3, 12, 7, c0);
        expect_at(c0 + 4, K_RST, 0, "R5");
        idle(5);
        wr(1, 1, 3, 13, 7, c1);
        expect_at(c0 + PULSE_N, K_RST, 0, "R5");
        expect_at(c1 + PULSE_N - 1, K_RST,  0, "R5");
        expect_at(c1 + PULSE_N - 1, K_BUSY, 1, "R5");
        expect_at(c1 + PULSE_N,     K_RST,  1, "R5");
        expect_at(c1 + PULSE_N,     K_PINS, pk(3, 13, 7), "R8");
        idle(PULSE_N + 2);

        // R6: power down cancels a pulse
        wr(1, 1, 2, 13, 7, c0);
        expect_at(c0, K_BUSY, 1, "R6");
        idle(3);
        wr(0, 1, 2, 13, 7, c1);
        expect_at(c1,     K_PWR,  0, "R6");
        expect_at(c1,     K_RST,  0, "R6");
        expect_at(c1,     K_BUSY, 0, "R6");
        expect_at(c1 + 4, K_BUSY, 0, "R6");
        idle(6);

        // R10: request left low keeps reset, idle release is immediate
        wr(1, 0, 2, 13, 7, c0);
        expect_at(c0 + HOLD_N,     K_BUSY, 0, "R10");
        expect_at(c0 + HOLD_N,     K_RST,  0, "R10");
        expect_at(c0 + HOLD_N + 2, K_RST,  0, "R10");
        idle(HOLD_N + 3);
        wr(1, 1, 2, 13, 7, c0);
        expect_at(c0, K_RST,  1, "R10");
        expect_at(c0, K_BUSY, 0, "R10");
        idle(2);

        // R2: reserved bits read as zero
        wr_raw(32'hFFFF_FFFF, c0);
        expect_at(c0, K_RD, 32'hC007_3F3F, "R2");
        idle(PULSE_N + 2);

        // R1: chip reset in the middle of a pulse
        wr(1, 1, 1, 2, 3, c0);
        idle(2);
        @(negedge clk);
        rst_n = 1'b0;
        expect_at(cyc, K_RST,  0, "R1");
        expect_at(cyc, K_PWR,  0, "R1");
        expect_at(cyc, K_BUSY, 0, "R1");
        expect_at(cyc, K_RD,   0, "R1");
        expect_at(cyc, K_PINS, 0, "R1");
        idle(2);
        rst_n = 1'b1;
        idle(2);

        while (exp_q.size() > 0) idle(1);
        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule